// File: doc/BRIEF.md
# Double-Data-Rate Strobe I/O Register Cell

This cell sits between the core and one group of pins of a DDR/DDR2 SDRAM style interface. On the write side it takes two data words per clock from the core and places them on the pin one after the other: the rising-edge word while the clock is high, then the falling-edge word while it is low. An active-low output-enable path controls the tri-state driver. A second enable register, clocked on the falling edge, keeps the pin in high impedance for half a cycle longer when driving starts. This gives a strobe pin its write preamble. When driving stops, the pin is released at once.

On the read side the cell takes an already phase-shifted read strobe. It captures one data word on each strobe edge and hands both words to the core together on a rising clock edge. A postamble gate forces the shifted strobe low outside a read burst. The core opens the gate with a one-cycle read-start pulse. The gate closes on the falling strobe edge that ends the burst, so any noise on the strobe line after that edge cannot clock the capture registers.

A small refresh stage also holds the 6-bit strobe delay setting for the external delay chain. It copies the DLL value only on an internal update pulse, which occurs once every eight clock cycles. The pin is modelled as a drive value plus an active-low drive enable, with a separate receive input.

Top module: `ddr_strobe_io`

## Requirements
- R1: `wr_hi` and `wr_lo` are sampled on a rising clock edge. In the cycle that follows, `pad_out` shows the `wr_hi` word while `clk` is high and the `wr_lo` word while `clk` is low.
- R2: `pad_oe_n` is 0 (pin driven) only if `wr_oe_n` was 0 at the previous rising edge. A 1 on `wr_oe_n` sampled at a rising edge releases the pin (`pad_oe_n` = 1) right after that same edge.
- R3: Suppose `wr_oe_n` = 0 is first sampled at a rising edge. Then `pad_oe_n` stays 1 for the high half of that cycle and goes 0 at the next falling clock edge (half-cycle write preamble).
- R4: Data on `pad_in` at a rising edge of `rd_strobe` appears on `rd_hi`, and data at the next falling strobe edge appears on `rd_lo`. Both change together at the next rising clock edge and hold for one cycle.
- R5: A `rd_start` = 1 sampled at a rising clock edge opens the postamble gate. The gate closes at the BEATS/2-th falling strobe edge (BEATS = 4 gives 2 falling edges). Strobe pulses while the gate is closed leave `rd_hi` and `rd_lo` unchanged.
- R6: A `rd_start` sampled at the first rising edge after a burst's last falling strobe edge reopens the gate with no idle cycle. Both bursts come out on `rd_hi`/`rd_lo` in consecutive cycles.
- R7: Count the rising edges after reset is released, with rst = 0 sampled, starting at 1. `dly_setting` loads `dll_setting` only at edges whose number is a multiple of UPD_PERIOD (8), and holds its value otherwise.
- R8: While `rst` = 1 at rising edges: `pad_oe_n` = 1, `pad_out` = 0, `rd_hi` = `rd_lo` = 0 and `dly_setting` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (strobe-domain flops clear asynchronously) |
| wr_hi | input | DW | Word driven during the high clock phase |
| wr_lo | input | DW | Word driven during the low clock phase |
| wr_oe_n | input | 1 | Active-low drive request from the core |
| pad_out | output | DW | Value driven onto the pin |
| pad_oe_n | output | 1 | Active-low pin drive enable, 1 = high impedance |
| rd_strobe | input | 1 | Phase-shifted read strobe from the pin |
| pad_in | input | DW | Value received from the pin |
| rd_start | input | 1 | One-cycle pulse that opens the postamble gate for one burst |
| rd_hi | output | DW | Word captured on the rising strobe edge |
| rd_lo | output | DW | Word captured on the falling strobe edge |
| dll_setting | input | DLY_W | Delay setting computed by the DLL |
| dly_setting | output | DLY_W | Delay setting held for the strobe delay chain |

## Verification
Two functions can act in the same cycle: the postamble gate closing on the last falling strobe edge of one burst, and the gate reopening for the next burst on the very next rising clock edge. The bench provokes this by issuing the second `rd_start` during the last strobe-low phase of the first burst, with no idle cycle between the two bursts. A scoreboard expects both bursts, word by word, in consecutive cycles. A strobe glitch after the second burst must then leave the last captured pair on the outputs, which shows that the reopen-then-close sequence left the gate closed.

// File: rtl/ddr_strobe_io_pkg.sv
package ddr_strobe_io_pkg;
  localparam int unsigned DLY_W_DEFAULT      = 6;
  localparam int unsigned UPD_PERIOD_DEFAULT = 8;
  localparam int unsigned BEATS_DEFAULT      = 4;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ddr_out_regs.sv
module ddr_out_regs #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] hi_d,
  input  logic [DW-1:0] lo_d,
  output logic [DW-1:0] pad_out
);
  logic [DW-1:0] q_hi;
  logic [DW-1:0] q_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_hi <= '0;
      q_lo <= '0;
    end else begin
      q_hi <= hi_d;
      q_lo <= lo_d;
    end
  end

  // clock-level select: high phase carries the rising-edge word
  assign pad_out = clk ? q_hi : q_lo;
endmodule

// File: rtl/ddr_oe_regs.sv
module ddr_oe_regs (
  input  logic clk,
  input  logic rst,
  input  logic oe_req_n,
  output logic pad_oe_n
);
  logic oe_rise_n;
  logic oe_fall_n;

  always_ff @(posedge clk) begin
    if (rst) oe_rise_n <= 1'b1;
    else     oe_rise_n <= oe_req_n;
  end

  // half-cycle later copy: delays the exit from high impedance only
  always_ff @(negedge clk) begin
    if (rst) oe_fall_n <= 1'b1;
    else     oe_fall_n <= oe_rise_n;
  end

  assign pad_oe_n = oe_rise_n | oe_fall_n;

  assert_drive_needs_request_R2: assert property (
    @(posedge clk) disable iff (rst) !pad_oe_n |-> !$past(oe_req_n))
    else $error("pin driven without a request");

  assert_preamble_half_R3: assert property (
    @(negedge clk) disable iff (rst) $fell(oe_rise_n) |-> pad_oe_n)
    else $error("pin left high impedance before the falling edge");
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
  parameter int unsigned BEATS = ddr_strobe_io_pkg::BEATS_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic strobe,
  output logic gate_open,
  output logic gated_strobe
);
  localparam int unsigned FALLS = BEATS / 2;
  localparam int unsigned CW    = ddr_strobe_io_pkg::cnt_width(FALLS);

  logic arm_tgl;
  logic done_tgl;

  always_ff @(posedge clk) begin
    if (rst)      arm_tgl <= 1'b0;
    else if (arm) arm_tgl <= ~arm_tgl;
  end

  assign gate_open    = arm_tgl ^ done_tgl;
  assign gated_strobe = strobe & gate_open;

  generate
    if (FALLS <= 1) begin : g_single
      always_ff @(negedge strobe or posedge rst) begin
        if (rst)            done_tgl <= 1'b0;
        else if (gate_open) done_tgl <= arm_tgl;
      end
    end else begin : g_count
      logic [CW-1:0] fall_cnt;
      always_ff @(negedge strobe or posedge rst) begin
        if (rst) begin
          fall_cnt <= '0;
          done_tgl <= 1'b0;
        end else if (gate_open) begin
          if (fall_cnt == CW'(FALLS - 1)) begin
            fall_cnt <= '0;
            done_tgl <= arm_tgl;
          end else begin
            fall_cnt <= fall_cnt + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ddr_in_regs.sv
module ddr_in_regs #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gstrobe,
  input  logic          gate_open,
  input  logic          arm,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] rd_hi,
  output logic [DW-1:0] rd_lo
);
  logic [DW-1:0] cap_rise;
  logic [DW-1:0] cap_fall;
  logic [DW-1:0] fall_hold;

  always_ff @(posedge gstrobe or posedge rst) begin
    if (rst) cap_rise <= '0;
    else     cap_rise <= pad_in;
  end

  always_ff @(negedge gstrobe or posedge rst) begin
    if (rst) cap_fall <= '0;
    else     cap_fall <= pad_in;
  end

  // transparent in the low clock phase, frozen across the rising edge
  always_latch begin
    if (!clk) fall_hold <= cap_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hi <= '0;
      rd_lo <= '0;
    end else begin
      rd_hi <= cap_rise;
      rd_lo <= fall_hold;
    end
  end

  assert_no_capture_closed_R5: assert property (
    @(posedge clk) disable iff (rst)
      (!gate_open && !$past(gate_open) && !$past(arm))
        |-> ($stable(cap_rise) && $stable(cap_fall)))
    else $error("capture register moved while the gate was closed");
endmodule

// File: rtl/dly_update.sv
module dly_update #(
  parameter int unsigned DLY_W  = ddr_strobe_io_pkg::DLY_W_DEFAULT,
  parameter int unsigned PERIOD = ddr_strobe_io_pkg::UPD_PERIOD_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] dll_setting,
  output logic [DLY_W-1:0] dly_setting
);
  localparam int unsigned CW = ddr_strobe_io_pkg::cnt_width(PERIOD);

  logic [CW-1:0] phase;
  logic          upd;

  always_ff @(posedge clk) begin
    if (rst)                          phase <= '0;
    else if (phase == CW'(PERIOD - 1)) phase <= '0;
    else                              phase <= phase + 1'b1;
  end

  assign upd = (phase == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)      dly_setting <= '0;
    else if (upd) dly_setting <= dll_setting;
  end

  assert_upd_single_R7: assert property (
    @(posedge clk) disable iff (rst) upd |=> !upd)
    else $error("update pulse longer than one cycle");

  assert_hold_between_R7: assert property (
    @(posedge clk) disable iff (rst) !upd |=> $stable(dly_setting))
    else $error("delay setting changed without an update pulse");
endmodule

// File: rtl/ddr_strobe_io.sv
module ddr_strobe_io #(
  parameter int unsigned DW         = 4,
  parameter int unsigned BEATS      = ddr_strobe_io_pkg::BEATS_DEFAULT,
  parameter int unsigned DLY_W      = ddr_strobe_io_pkg::DLY_W_DEFAULT,
  parameter int unsigned UPD_PERIOD = ddr_strobe_io_pkg::UPD_PERIOD_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    wr_hi,
  input  logic [DW-1:0]    wr_lo,
  input  logic             wr_oe_n,
  output logic [DW-1:0]    pad_out,
  output logic             pad_oe_n,
  input  logic             rd_strobe,
  input  logic [DW-1:0]    pad_in,
  input  logic             rd_start,
  output logic [DW-1:0]    rd_hi,
  output logic [DW-1:0]    rd_lo,
  input  logic [DLY_W-1:0] dll_setting,
  output logic [DLY_W-1:0] dly_setting
);
  logic gate_open;
  logic gated_strobe;

  ddr_out_regs #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .hi_d(wr_hi), .lo_d(wr_lo), .pad_out(pad_out)
  );

  ddr_oe_regs u_oe (
    .clk(clk), .rst(rst), .oe_req_n(wr_oe_n), .pad_oe_n(pad_oe_n)
  );

  strobe_gate #(.BEATS(BEATS)) u_gate (
    .clk(clk), .rst(rst), .arm(rd_start), .strobe(rd_strobe),
    .gate_open(gate_open), .gated_strobe(gated_strobe)
  );

  ddr_in_regs #(.DW(DW)) u_in (
    .clk(clk), .rst(rst), .gstrobe(gated_strobe), .gate_open(gate_open),
    .arm(rd_start), .pad_in(pad_in), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  dly_update #(.DLY_W(DLY_W), .PERIOD(UPD_PERIOD)) u_dly (
    .clk(clk), .rst(rst), .dll_setting(dll_setting), .dly_setting(dly_setting)
  );
endmodule

// File: tb/sim_ddr_strobe_io.sv
module sim_ddr_strobe_io;
  localparam int CLK_PERIOD = 8;
  localparam int DW = 4;
  localparam int DLY_W = 6;
  localparam int UPD = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DW-1:0]    wr_hi = '0, wr_lo = '0;
  logic             wr_oe_n = 1'b1;
  logic [DW-1:0]    pad_out;
  logic             pad_oe_n;
  logic             rd_strobe = 1'b0;
  logic [DW-1:0]    pad_in = '0;
  logic             rd_start = 1'b0;
  logic [DW-1:0]    rd_hi, rd_lo;
  logic [DLY_W-1:0] dll_setting = '0;
  logic [DLY_W-1:0] dly_setting;

  int vectors = 0;
  int miscmp = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct packed {
    int          cyc;
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
  } exp_t;
  exp_t  sb[$];
  string sbr[$];
  logic [DW-1:0] last_hi = '0, last_lo = '0;

  ddr_strobe_io #(.DW(DW), .BEATS(4), .DLY_W(DLY_W), .UPD_PERIOD(UPD)) u0 (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_oe_n(wr_oe_n),
    .pad_out(pad_out), .pad_oe_n(pad_oe_n), .rd_strobe(rd_strobe),
    .pad_in(pad_in), .rd_start(rd_start), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .dll_setting(dll_setting), .dly_setting(dly_setting)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int c, input logic [DW-1:0] h, input logic [DW-1:0] l,
                      input string req);
    exp_t e;
    e.cyc = c; e.hi = h; e.lo = l;
    sb.push_back(e);
    sbr.push_back(req);
  endtask

  // scoreboard monitor: compares read outputs a quarter cycle after each edge
  always @(posedge clk) begin : mon
    exp_t  e;
    string r;
    #(CLK_PERIOD/4);
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      e = sb.pop_front();
      r = sbr.pop_front();
      chk({r, " slot"}, 32'(cyc), 32'(e.cyc));
      chk({r, " rd_hi"}, 32'(rd_hi), 32'(e.hi));
      chk({r, " rd_lo"}, 32'(rd_lo), 32'(e.lo));
    end
  end

  // R7 model: delay setting reloads on every UPD-th edge after reset
  logic [DLY_W-1:0] model_dly = '0;
  int n_edges = 0;
  always @(posedge clk) begin
    if (rst) begin
      n_edges = 0;
      model_dly = '0;
    end else begin
      n_edges++;
      if (n_edges % UPD == 0) model_dly = dll_setting;
    end
  end
  always @(negedge clk) begin
    if (!finished && cyc > 0) chk("R7 dly_setting", 32'(dly_setting), 32'(model_dly));
    dll_setting <= dll_setting + 6'd5;
  end

  // caller is in the second half of a cycle; rd_start is sampled at the next edge
  task automatic rd_burst(input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                          input logic [DW-1:0] b2, input logic [DW-1:0] b3,
                          input bit glitch, input string req);
    int c;
    c = cyc;
    rd_start = 1'b1;
    push(c + 2, b0, b1, req);
    push(c + 3, b2, b3, req);
    if (glitch) push(c + 4, b2, b3, "R5 postamble glitch");
    @(posedge clk);
    #1 rd_start = 1'b0; pad_in = b0;
    #1 rd_strobe = 1'b1;
    #2 pad_in = b1;
    #2 rd_strobe = 1'b0;
    @(posedge clk);
    #1 pad_in = b2;
    #1 rd_strobe = 1'b1;
    #2 pad_in = b3;
    #2 rd_strobe = 1'b0;
    last_hi = b2; last_lo = b3;
    if (glitch) begin
      @(posedge clk);
      #1 pad_in = ~b3;
      #1 rd_strobe = 1'b1;
      #1 pad_in = ~b2;
      #1 rd_strobe = 1'b0;
    end
  endtask

  task automatic stray_pulse();
    push(cyc + 2, last_hi, last_lo, "R5 idle glitch");
    @(posedge clk);
    #1 pad_in = 4'hC;
    #1 rd_strobe = 1'b1;
    #1 pad_in = 4'h3;
    #1 rd_strobe = 1'b0;
  endtask

  initial begin : wdog
    #(CLK_PERIOD * 4000);
    if (!finished) begin
      finished = 1'b1;
      miscmp++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #2;
    chk("R8 pad_oe_n", 32'(pad_oe_n), 32'd1);
    chk("R8 pad_out", 32'(pad_out), 32'd0);
    chk("R8 rd_hi", 32'(rd_hi), 32'd0);
    chk("R8 rd_lo", 32'(rd_lo), 32'd0);
    chk("R8 dly_setting", 32'(dly_setting), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // write: enable with preamble, two DDR cycles, release
    @(negedge clk);
    wr_oe_n = 1'b0; wr_hi = 4'hA; wr_lo = 4'h5;
    @(posedge clk); #2;
    chk("R3 preamble high phase", 32'(pad_oe_n), 32'd1);
    @(negedge clk);
    wr_hi = 4'h3; wr_lo = 4'hC;
    #2;
    chk("R3 drive after falling edge", 32'(pad_oe_n), 32'd0);
    chk("R1 low-phase word", 32'(pad_out), 32'h5);
    @(posedge clk); #2;
    chk("R1 high-phase word", 32'(pad_out), 32'h3);
    chk("R2 still driven", 32'(pad_oe_n), 32'd0);
    @(negedge clk);
    wr_oe_n = 1'b1;
    #2;
    chk("R1 low-phase word 2", 32'(pad_out), 32'hC);
    @(posedge clk); #2;
    chk("R2 immediate release", 32'(pad_oe_n), 32'd1);
    @(negedge clk); #2;
    chk("R2 stays released", 32'(pad_oe_n), 32'd1);

    // read: idle glitch, burst with postamble glitch, back-to-back bursts
    stray_pulse();
    rd_burst(4'h1, 4'hE, 4'h7, 4'h8, 1'b1, "R4 burst A");
    rd_burst(4'h2, 4'hD, 4'h9, 4'h6, 1'b0, "R6 burst B");
    rd_burst(4'hF, 4'h0, 4'h4, 4'hB, 1'b1, "R6 burst C");
    repeat (6) @(negedge clk);
    chk("R6 scoreboard drained", 32'(sb.size()), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule